// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 18-bit words. The write side and the read side each have their own clock and their own synchronous reset. The two clocks may be the same net or may be unrelated. Each side moves its pointer across to the other domain as a Gray-coded value through a two-stage synchronizer. As a result, every flag is computed from a view of the other side that may be out of date, and is therefore conservative.

A mode input chooses one of two output timings. In standard timing, the consumer pulls each word onto the output with a read request, and the read-side status bit means "empty". In fall-through timing, the oldest word is moved onto the output on its own, and the status bit means "output holds a valid word". The write-side status bit also has two meanings: "full" in standard timing and "ready to accept" in fall-through timing.

Almost-empty and almost-full thresholds are set at run time. The producer raises the load input and then writes offsets on the data bus through the write port. The offsets are stored in a fixed order, almost-empty first and almost-full second. A half-full flag is also provided. An output-enable input forces the data output to zero when it is low.

Top module: `fifo_dc_top`

## Requirements
- R1: After reset, in standard timing: `rd_stat`=1 (empty), `wr_stat`=0 (not full), `dout`=0, `almost_empty`=1, `almost_full`=0, `half_full`=0. Both offsets reset to 7.
- R2: In standard timing (`fwft`=0), `dout` changes only on a read clock edge where `ren`=1 and the buffer holds a word. The words come out in the order they were written.
- R3: When the buffer is full, a write is ignored. When it is empty, a read is ignored. Neither changes a pointer, and later traffic keeps its order.
- R4: In fall-through timing (`fwft`=1), a word written into an empty buffer appears on `dout` after the third read clock edge that follows the write edge, with no `ren`. That word stays on `dout` until a read edge with `ren`=1 replaces it.
- R5: `wr_stat` is 1 when full in standard timing and 1 when not full (ready) in fall-through timing. `rd_stat` is 1 when empty in standard timing and 1 when `dout` holds a valid word in fall-through timing. In fall-through timing the buffer holds DEPTH+1 words, including the output word.
- R6: `half_full` is 1 exactly when the write side's word count is greater than DEPTH/2.
- R7: `almost_empty` is 1 when the read side's word count is at most the almost-empty offset. In fall-through timing this count includes the word held on `dout`.
- R8: `almost_full` is 1 when DEPTH minus the write side's word count is at most the almost-full offset.
- R9: A write edge with `ld`=1 and `wen`=1 stores `din[ADDR_W-1:0]` into an offset register instead of into the buffer. The first such write stores the almost-empty offset and the second stores the almost-full offset. A third write wraps around to the almost-empty offset. A cycle with `ld`=0 restarts the sequence at the almost-empty offset.
- R10: When `oe`=0, `dout` reads 0. When `oe`=1, `dout` shows the held output word.
- R11: Pointers move between the clock domains as Gray code, so each step changes at most one bit. After a write edge into an empty buffer, the read side sees the word after the second read edge. After a read edge, the write side sees the freed slot after the third write edge, counting the read edge as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write side |
| wen | input | 1 | Write request |
| ld | input | 1 | Offset-load select for write requests |
| din | input | 18 | Write data, or offset value while loading |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read side |
| ren | input | 1 | Read request |
| oe | input | 1 | Output data gate |
| fwft | input | 1 | 1 selects fall-through timing, 0 selects standard timing |
| dout | output | 18 | Output word |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Read-side level at or below the almost-empty offset |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| half_full | output | 1 | Write-side level above DEPTH/2 |

## Verification
The buffer is tested with a single isolated word, short bursts, a complete fill followed by extra writes, and a complete drain followed by extra reads. The single word measures the crossing latency of each status flag. The fill and drain step across every level threshold one word at a time, so an off-by-one compare is exposed. Both timing modes are run on the same patterns, which separates the output-register behaviour and the two meanings of each status flag. Load sequences of two and three offset writes, with and without `ld` dropping between them, show the order of the offset registers and the wrap of the sequence.

// File: rtl/fifo_dc_pkg.sv
package fifo_dc_pkg;
    localparam int DATA_W     = 18;
    localparam int DEF_OFFSET = 7;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        SEL_LO_MARK = 1'b0,
        SEL_HI_MARK = 1'b1
    } off_sel_e;

    typedef struct packed {
        logic full;
        logic almost_full;
        logic half_full;
    } wr_flags_t;
endpackage

// File: rtl/fifo_dc_ptr_sync.sv
module fifo_dc_ptr_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit is the parity of all Gray bits at and above it
    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_out[i] = ^stage2[W-1:i];
    end
endmodule

// File: rtl/fifo_dc_wr_ctrl.sv
module fifo_dc_wr_ctrl
    import fifo_dc_pkg::*;
#(
    parameter  int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_data,
    input  logic [PTR_W-1:0]  rptr_sync,
    output logic [ADDR_W-1:0] waddr,
    output logic [PTR_W-1:0]  wptr_gray,
    output logic              push,
    output logic [ADDR_W-1:0] lo_mark,
    output wr_flags_t         flags
);
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  wptr_nxt;
    logic [PTR_W-1:0]  level;
    logic [ADDR_W-1:0] hi_mark;
    off_sel_e          sel;

    assign level             = wptr - rptr_sync;
    assign flags.full        = (level == PTR_W'(DEPTH));
    assign flags.almost_full = (PTR_W'(DEPTH) - level) <= {1'b0, hi_mark};
    assign flags.half_full   = level > PTR_W'(DEPTH / 2);
    assign push              = wen && !ld && !flags.full;
    assign wptr_nxt          = wptr + 1'b1;
    assign waddr             = wptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr      <= '0;
            wptr_gray <= '0;
        end else if (push) begin
            wptr      <= wptr_nxt;
            wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // Offset load sequencer: low mark first, then high mark, then wrap
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_mark <= ADDR_W'(DEF_OFFSET);
            hi_mark <= ADDR_W'(DEF_OFFSET);
            sel     <= SEL_LO_MARK;
        end else if (!ld) begin
            sel <= SEL_LO_MARK;
        end else if (wen) begin
            if (sel == SEL_LO_MARK) begin
                lo_mark <= ld_data;
                sel     <= SEL_HI_MARK;
            end else begin
                hi_mark <= ld_data;
                sel     <= SEL_LO_MARK;
            end
        end
    end
endmodule

// File: rtl/fifo_dc_rd_ctrl.sv
module fifo_dc_rd_ctrl
    import fifo_dc_pkg::*;
#(
    parameter  int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ren,
    input  logic              fwft,
    input  logic [PTR_W-1:0]  wptr_sync,
    input  logic [ADDR_W-1:0] lo_mark,
    input  word_t             mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [PTR_W-1:0]  rptr_gray,
    output logic              mem_empty,
    output logic              ovalid,
    output word_t             dout_q,
    output logic              almost_empty
);
    logic [PTR_W-1:0] rptr;
    logic [PTR_W-1:0] rptr_nxt;
    logic [PTR_W-1:0] level;
    logic             pop;

    assign mem_empty    = (wptr_sync == rptr);
    assign pop          = !mem_empty && (fwft ? (!ovalid || ren) : ren);
    assign rptr_nxt     = rptr + 1'b1;
    assign raddr        = rptr[ADDR_W-1:0];
    assign level        = (wptr_sync - rptr) + PTR_W'(fwft && ovalid);
    assign almost_empty = level <= {1'b0, lo_mark};

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            rptr_gray <= '0;
            dout_q    <= '0;
            ovalid    <= 1'b0;
        end else if (pop) begin
            rptr      <= rptr_nxt;
            rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            dout_q    <= mem_rdata;
            ovalid    <= 1'b1;
        end else if (ren) begin
            ovalid    <= 1'b0;
        end
    end
endmodule

// File: rtl/fifo_dc_top.sv
module fifo_dc_top
    import fifo_dc_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wen,
    input  logic              ld,
    input  logic [DATA_W-1:0] din,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              ren,
    input  logic              oe,
    input  logic              fwft,
    output logic [DATA_W-1:0] dout,
    output logic              rd_stat,
    output logic              wr_stat,
    output logic              almost_empty,
    output logic              almost_full,
    output logic              half_full
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    word_t             mem [DEPTH];
    word_t             mem_rdata;
    word_t             dout_q;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [ADDR_W-1:0] lo_mark;
    logic [PTR_W-1:0]  wptr_gray;
    logic [PTR_W-1:0]  rptr_gray;
    logic [PTR_W-1:0]  wptr_s;
    logic [PTR_W-1:0]  rptr_s;
    logic              push;
    logic              mem_empty;
    logic              ovalid;
    wr_flags_t         wflags;

    fifo_dc_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk       (wclk),
        .rst       (wrst),
        .wen       (wen),
        .ld        (ld),
        .ld_data   (din[ADDR_W-1:0]),
        .rptr_sync (rptr_s),
        .waddr     (waddr),
        .wptr_gray (wptr_gray),
        .push      (push),
        .lo_mark   (lo_mark),
        .flags     (wflags)
    );

    fifo_dc_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk          (rclk),
        .rst          (rrst),
        .ren          (ren),
        .fwft         (fwft),
        .wptr_sync    (wptr_s),
        .lo_mark      (lo_mark),
        .mem_rdata    (mem_rdata),
        .raddr        (raddr),
        .rptr_gray    (rptr_gray),
        .mem_empty    (mem_empty),
        .ovalid       (ovalid),
        .dout_q       (dout_q),
        .almost_empty (almost_empty)
    );

    fifo_dc_ptr_sync #(.W(PTR_W)) u_w2r (
        .clk     (rclk),
        .rst     (rrst),
        .gray_in (wptr_gray),
        .bin_out (wptr_s)
    );

    fifo_dc_ptr_sync #(.W(PTR_W)) u_r2w (
        .clk     (wclk),
        .rst     (wrst),
        .gray_in (rptr_gray),
        .bin_out (rptr_s)
    );

    always_ff @(posedge wclk) begin
        if (push) begin
            mem[waddr] <= din;
        end
    end

    assign mem_rdata   = mem[raddr];
    assign dout        = oe ? dout_q : '0;
    assign rd_stat     = fwft ? ovalid : mem_empty;
    assign wr_stat     = fwft ? !wflags.full : wflags.full;
    assign almost_full = wflags.almost_full;
    assign half_full   = wflags.half_full;
endmodule

// File: rtl/fifo_dc_checker.sv
module fifo_dc_checker #(
    parameter  int DEPTH  = 256,
    localparam int PTR_W  = $clog2(DEPTH) + 1
) (
    input logic             wclk,
    input logic             wrst,
    input logic             rclk,
    input logic             rrst,
    input logic             wen,
    input logic             ren,
    input logic             fwft,
    input logic             full,
    input logic             almost_full,
    input logic             half_full,
    input logic             mem_empty,
    input logic [PTR_W-1:0] wptr_gray,
    input logic [PTR_W-1:0] rptr_gray,
    input logic [17:0]      dout_q
);
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (wrst)
        full && wen |=> $stable(wptr_gray));

    p_no_underflow_r3: assert property (@(posedge rclk) disable iff (rrst)
        mem_empty |=> $stable(rptr_gray));

    p_wgray_step_r11: assert property (@(posedge wclk) disable iff (wrst)
        wen |=> $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

    p_rgray_step_r11: assert property (@(posedge rclk) disable iff (rrst)
        ren |=> $countones(rptr_gray ^ $past(rptr_gray)) <= 1);

    p_std_hold_r2: assert property (@(posedge rclk) disable iff (rrst)
        !fwft && !ren |=> $stable(dout_q));

    p_full_half_r6: assert property (@(posedge wclk) disable iff (wrst)
        full |-> half_full);

    p_full_af_r8: assert property (@(posedge wclk) disable iff (wrst)
        full |-> almost_full);
endmodule

bind fifo_dc_top fifo_dc_checker #(.DEPTH(DEPTH)) u_chk (
    .wclk        (wclk),
    .wrst        (wrst),
    .rclk        (rclk),
    .rrst        (rrst),
    .wen         (wen),
    .ren         (ren),
    .fwft        (fwft),
    .full        (wflags.full),
    .almost_full (wflags.almost_full),
    .half_full   (wflags.half_full),
    .mem_empty   (mem_empty),
    .wptr_gray   (wptr_gray),
    .rptr_gray   (rptr_gray),
    .dout_q      (dout_q)
);

// File: tb/fifo_dc_top_bench.sv
module fifo_dc_top_bench;
    localparam int D = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wen = 1'b0, ren = 1'b0, ld = 1'b0, oe = 1'b1, fwft = 1'b0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic        rd_stat, wr_stat, almost_empty, almost_full, half_full;
    int          checks = 0;
    int          fails  = 0;

    always #10 clk = ~clk;

    fifo_dc_top #(.DEPTH(D)) u_fifo_dc_top (
        .wclk(clk), .wrst(rst), .wen(wen), .ld(ld), .din(din),
        .rclk(clk), .rrst(rst), .ren(ren), .oe(oe), .fwft(fwft),
        .dout(dout), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .almost_empty(almost_empty), .almost_full(almost_full),
        .half_full(half_full)
    );

    function automatic logic [17:0] wv(int i);
        return 18'(i * 37 + 5);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle from a falling edge; results are sampled at the next falling edge
    task automatic tick(bit w, bit r, bit l, logic [17:0] d);
        wen = w; ren = r; ld = l; din = d;
        @(negedge clk);
        wen = 1'b0; ren = 1'b0; ld = 1'b0; din = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit mode);
        rst = 1'b1; fwft = mode; oe = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk("R1", "rd_stat", rd_stat, 1);
        chk("R1", "wr_stat", wr_stat, 0);
        chk("R1", "dout", dout, 0);
        chk("R1", "almost_empty", almost_empty, 1);
        chk("R1", "almost_full", almost_full, 0);
        chk("R1", "half_full", half_full, 0);
    endtask

    task automatic t_std_single;
        do_reset(1'b0);
        tick(1, 0, 0, wv(1));
        chk("R11", "empty after write edge", rd_stat, 1);
        idle(1);
        chk("R11", "empty one edge later", rd_stat, 1);
        idle(1);
        chk("R11", "empty clears two edges later", rd_stat, 0);
        idle(2);
        chk("R2", "no data without read", dout, 0);
        tick(0, 1, 0, '0);
        chk("R2", "data after read", dout, wv(1));
        chk("R2", "empty after last read", rd_stat, 1);
        oe = 1'b0; #1;
        chk("R10", "dout gated", dout, 0);
        oe = 1'b1; #1;
        chk("R10", "dout ungated", dout, wv(1));
        for (int i = 0; i < 5; i++) tick(1, 0, 0, wv(10 + i));
        idle(3);
        for (int i = 0; i < 5; i++) begin
            tick(0, 1, 0, '0);
            chk("R2", "burst order", dout, wv(10 + i));
        end
    endtask

    task automatic t_std_fill;
        do_reset(1'b0);
        for (int w = 1; w <= D + 3; w++) begin
            tick(1, 0, 0, wv(w - 1));
            if (w == D / 2)     chk("R6", "half at D/2", half_full, 0);
            if (w == D / 2 + 1) chk("R6", "half above D/2", half_full, 1);
            if (w == D - 8)     chk("R8", "af free 8", almost_full, 0);
            if (w == D - 7)     chk("R8", "af free 7", almost_full, 1);
            if (w == D - 1)     chk("R5", "not full", wr_stat, 0);
            if (w == D)         chk("R5", "full", wr_stat, 1);
        end
        idle(3);
        for (int k = 1; k <= D + 3; k++) begin
            tick(0, 1, 0, '0);
            chk("R3", "drain data", dout, (k <= D) ? wv(k - 1) : wv(D - 1));
            if (k == 2)     chk("R11", "full still seen", wr_stat, 1);
            if (k == 3)     chk("R11", "full clears", wr_stat, 0);
            if (k == D - 8) chk("R7", "ae level 8", almost_empty, 0);
            if (k == D - 7) chk("R7", "ae level 7", almost_empty, 1);
        end
        chk("R3", "empty after drain", rd_stat, 1);
        tick(1, 0, 0, wv(900));
        idle(3);
        tick(0, 1, 0, '0);
        chk("R3", "pointers intact", dout, wv(900));
    endtask

    task automatic t_fwft_single;
        do_reset(1'b1);
        chk("R5", "fwft not ready", rd_stat, 0);
        chk("R5", "fwft input ready", wr_stat, 1);
        tick(1, 0, 0, wv(50));
        chk("R4", "no word after edge 1", rd_stat, 0);
        idle(2);
        chk("R4", "no word after edge 2", rd_stat, 0);
        idle(1);
        chk("R4", "ready after edge 3", rd_stat, 1);
        chk("R4", "word fell through", dout, wv(50));
        idle(2);
        chk("R4", "word held", dout, wv(50));
        tick(0, 1, 0, '0);
        chk("R5", "not ready after take", rd_stat, 0);
    endtask

    task automatic t_fwft_fill;
        do_reset(1'b1);
        for (int w = 1; w <= D + 2; w++) begin
            tick(1, 0, 0, wv(w + 300));
            if (w == D)     chk("R5", "fwft ready at D", wr_stat, 1);
            if (w == D + 1) chk("R5", "fwft full at D+1", wr_stat, 0);
        end
        idle(3);
        chk("R4", "first word out", dout, wv(301));
        for (int k = 1; k <= D; k++) begin
            tick(0, 1, 0, '0);
            chk("R3", "fwft drain", dout, wv(k + 301));
        end
        chk("R5", "still ready", rd_stat, 1);
        tick(0, 1, 0, '0);
        chk("R5", "drained", rd_stat, 0);
    endtask

    task automatic t_load;
        // Sequence restarts at the low mark once ld drops
        do_reset(1'b0);
        tick(0, 0, 1, 18'd0);
        tick(1, 0, 1, 18'd2);
        idle(1);
        tick(1, 0, 1, 18'd4);
        for (int i = 0; i < 3; i++) tick(1, 0, 0, wv(i));
        idle(3);
        chk("R9", "ae restart loads low mark", almost_empty, 1);
        // Three loads: low=5, high=10, low=3 (wrap)
        do_reset(1'b0);
        tick(1, 0, 1, 18'd5);
        tick(1, 0, 1, 18'd10);
        tick(1, 0, 1, 18'd3);
        idle(3);
        chk("R9", "load words not stored", rd_stat, 1);
        for (int i = 0; i < 4; i++) tick(1, 0, 0, wv(1000 + i));
        idle(3);
        chk("R9", "ae with low mark 3", almost_empty, 0);
        for (int i = 4; i < 246; i++) begin
            tick(1, 0, 0, wv(1000 + i));
            if (i == 244) chk("R9", "af free 11", almost_full, 0);
            if (i == 245) chk("R9", "af free 10", almost_full, 1);
        end
        idle(3);
        for (int k = 1; k <= 243; k++) begin
            tick(0, 1, 0, '0);
            if (k == 1)   chk("R9", "first real word", dout, wv(1000));
            if (k == 242) chk("R7", "ae level 4", almost_empty, 0);
            if (k == 243) chk("R7", "ae level 3", almost_empty, 1);
        end
    endtask

    initial begin
        idle(1);
        t_reset();
        t_std_single();
        t_std_fill();
        t_fwft_single();
        t_fwft_fill();
        t_load();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule